// File: doc/BRIEF.md
# Multi-PHY Receive Cell Poller

This block is the cell-layer master on a shared receive bus that serves several PHY ports. It steps a 5-bit port address through a fixed list of port addresses, with the null address 1Fh placed between any two of them. For each polled port it reads the shared cell-available line one clock later. A high-impedance or unknown level on that line counts as "no cell". Polling never stops, including while a cell is being transferred, so the block always knows which ports hold a complete cell.

When no cell transfer is running, or when the last word of the current cell is being requested, the block picks the next port by round-robin among the ports that reported a cell. The search starts just after the port served last. Selection is a handshake. For one clock the chosen port's address sits on the bus while the active-low enable is held high. The enable then goes low for exactly one cell's worth of clocks, one word per clock. Each 16-bit word arrives one clock after the enable clock that requested it. The block forwards it with first and last markers and with the source port address. It flags any word on which the start-of-cell input is not high on the first word alone.

Top module: `mphy_rx_poller`

## Requirements
- R1: While reset is held and on the first clock after it, the enable output is high (1), the address output is 1Fh and no output word is valid.
- R2: While no port is being selected, the address output alternates between a port address and 1Fh. The port addresses follow the configured list in order (default 01h, 03h, 05h, 07h) and wrap around.
- R3: A port whose available line was high one clock after its address was presented becomes eligible and is read. A port that answered low is never read.
- R4: A read starts with one clock in which the address output equals the chosen port and the enable is high. The enable is then low for exactly 27 consecutive clocks.
- R5: Each cell is delivered as 27 valid output words in arrival order. The first word carries the first-word marker, the 27th carries the last-word marker, and every word carries the 5-bit address of its port.
- R6: When several ports hold cells, service rotates among them in list order, starting after the port served last. A port is never served twice in a row while another eligible port waits.
- R7: The error output is high on a word when the start-of-cell input disagrees with the word position. It fires when start-of-cell is absent on word 0, or when it is present on any of words 1 to 26.
- R8: While cell words are being requested, every clock that shows a port address on the address output is followed either by 1Fh or by the end of the enable-low run.
- R9: A listed port whose available line is left undriven (high impedance) is treated as holding no cell and is never read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_addr | output | 5 | Port address driven onto the shared bus |
| phy_en_n | output | 1 | Active-low read enable |
| phy_clav | input | 1 | Shared cell-available line, may float |
| phy_data | input | 16 | Receive data word |
| phy_soc | input | 1 | Start-of-cell flag from the selected port |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output word |
| out_sof | output | 1 | First word of a cell |
| out_eof | output | 1 | Last word of a cell |
| out_port | output | 5 | Address of the port the word came from |
| out_err | output | 1 | Start-of-cell position error on this word |

## Verification
The hardest situation to reach is the handover at the end of a cell. There, a poll result for the port just served and a pick for the next port meet in the same clocks. A stale "available" answer taken before the read could then wrongly pull that port back in. The bench reaches it by loading two cells into each of three ports at once. Each port is then polled again during its own read, and every pick after the first falls on the final enable clock of a cell. The bench then checks that the service order keeps rotating and that each port gives exactly its two cells.

// File: rtl/mphy_rx_poller.sv
module mphy_rx_poller #(
  parameter int NPORT = 4,
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int CELL_WORDS = 27,
  parameter logic [NPORT*AW-1:0] PORTS = {5'h07, 5'h05, 5'h03, 5'h01}
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] phy_addr,
  output logic          phy_en_n,
  input  logic          phy_clav,
  input  logic [DW-1:0] phy_data,
  input  logic          phy_soc,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic [AW-1:0] out_port,
  output logic          out_err
);
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int CW = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;
  localparam logic [AW-1:0] NULLA = {AW{1'b1}};
  localparam logic [CW-1:0] LASTW = CW'(CELL_WORDS - 1);
  localparam logic [IW-1:0] LASTP = IW'(NPORT - 1);

  function automatic logic [AW-1:0] port_at(input logic [IW-1:0] i);
    return PORTS[int'(i)*AW +: AW];
  endfunction

  logic [NPORT-1:0] avail;
  logic [IW-1:0]    pidx, pres_idx, smp_idx, last, tgt, cur, pick_idx;
  logic             nxt_null, pres_v, smp_v;
  logic             sel_cyc, busy, en_d, pick_v;
  logic [CW-1:0]    wcnt, rx_idx;

  wire clav_ok   = (phy_clav === 1'b1);
  wire last_word = busy && (wcnt == LASTW);
  wire can_sel   = pick_v && !sel_cyc && (!busy || last_word);
  wire rx_first  = (rx_idx == '0);

  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int off = NPORT; off >= 1; off--) begin
      int j;
      j = (int'(last) + off) % NPORT;
      if (avail[j]) begin
        pick_v   = 1'b1;
        pick_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_addr <= NULLA;
      phy_en_n <= 1'b1;
      avail    <= '0;
      pidx     <= '0;
      pres_idx <= '0;
      smp_idx  <= '0;
      last     <= LASTP;
      tgt      <= '0;
      cur      <= '0;
      nxt_null <= 1'b0;
      pres_v   <= 1'b0;
      smp_v    <= 1'b0;
      sel_cyc  <= 1'b0;
      busy     <= 1'b0;
      wcnt     <= '0;
      en_d     <= 1'b0;
      rx_idx   <= '0;
    end else begin
      en_d   <= ~phy_en_n;
      pres_v <= 1'b0;
      smp_v  <= pres_v;
      smp_idx <= pres_idx;
      if (smp_v) avail[smp_idx] <= clav_ok;

      if (!can_sel) begin
        if (!nxt_null) begin
          phy_addr <= port_at(pidx);
          pres_v   <= 1'b1;
          pres_idx <= pidx;
          nxt_null <= 1'b1;
        end else begin
          phy_addr <= NULLA;
          nxt_null <= 1'b0;
          pidx     <= (pidx == LASTP) ? '0 : pidx + 1'b1;
        end
      end

      if (can_sel) begin
        sel_cyc  <= 1'b1;
        tgt      <= pick_idx;
        phy_addr <= port_at(pick_idx);
        phy_en_n <= 1'b1;
        busy     <= 1'b0;
        avail[pick_idx] <= 1'b0;
        if (pres_v && pres_idx == pick_idx) smp_v <= 1'b0;
      end else if (sel_cyc) begin
        sel_cyc  <= 1'b0;
        busy     <= 1'b1;
        wcnt     <= '0;
        cur      <= tgt;
        last     <= tgt;
        phy_en_n <= 1'b0;
      end else if (busy) begin
        if (last_word) begin
          busy     <= 1'b0;
          phy_en_n <= 1'b1;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end

      if (en_d) rx_idx <= (rx_idx == LASTW) ? '0 : rx_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_port  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= en_d;
      out_sof   <= en_d && rx_first;
      out_eof   <= en_d && (rx_idx == LASTW);
      out_err   <= en_d && (phy_soc != rx_first);
      if (en_d) begin
        out_data <= phy_data;
        out_port <= port_at(cur);
      end
    end
  end
endmodule

// File: rtl/poller_chk.sv
module poller_chk #(
  parameter int AW = 5,
  parameter int CELL_WORDS = 27
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] phy_addr,
  input logic          phy_en_n,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_eof,
  input logic          out_err,
  input logic [AW-1:0] out_port
);
  localparam int RW = $clog2(CELL_WORDS + 2) + 1;
  localparam logic [AW-1:0] NULLA = {AW{1'b1}};
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (phy_en_n) run <= '0;
    else if (run != {RW{1'b1}}) run <= run + 1'b1;
  end

  // R4
  sel_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_en_n) |-> ($past(phy_addr) != NULLA));

  // R4
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_en_n) |-> (run == RW'(CELL_WORDS)));

  // R4
  run_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(CELL_WORDS));

  // R8
  poll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_en_n && phy_addr != NULLA) |=> (phy_en_n || phy_addr == NULLA));

  // R5
  marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof || out_err) |-> out_valid);

  // R5
  tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_port != NULLA));
endmodule

bind mphy_rx_poller poller_chk #(.AW(AW), .CELL_WORDS(CELL_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .phy_en_n(phy_en_n),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .out_err(out_err), .out_port(out_port)
);

// File: tb/sim_mphy_rx_poller.sv
`timescale 1ns/1ps
module sim_mphy_rx_poller;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  phy_addr;
  logic        phy_en_n;
  wire         phy_clav;
  logic        clav_drv = 1'b0, clav_val = 1'b0;
  logic [15:0] phy_data = '0;
  logic        phy_soc = 1'b0;
  logic        out_valid, out_sof, out_eof, out_err;
  logic [15:0] out_data;
  logic [4:0]  out_port;

  assign phy_clav = clav_drv ? clav_val : 1'bz;

  mphy_rx_poller u0 (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .phy_en_n(phy_en_n),
    .phy_clav(phy_clav), .phy_data(phy_data), .phy_soc(phy_soc),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_port(out_port), .out_err(out_err)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int cells [32];
  int soc_mode = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit modeled(input logic [4:0] a);
    return (a == 5'h01 || a == 5'h03 || a == 5'h07);
  endfunction

  // PHY side model
  initial begin
    logic [4:0] paddr, sel;
    logic pen;
    bit sel_v;
    int k;
    paddr = 5'h1F; pen = 1'b1; sel = '0; sel_v = 0; k = 0;
    for (int i = 0; i < 32; i++) cells[i] = 0;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        sel_v = 0; pen = 1'b1; paddr = 5'h1F;
        clav_drv <= 1'b0;
      end else begin
        if (phy_en_n == 1'b0 && pen == 1'b1) begin
          sel = paddr; sel_v = 1; k = 0;
          if (cells[sel] > 0) cells[sel] = cells[sel] - 1;
        end
        if (phy_en_n == 1'b0 && sel_v && k < 27) begin
          phy_data <= {3'b000, sel, 8'(k)};
          case (soc_mode)
            1: phy_soc <= 1'b0;
            2: phy_soc <= (k == 0) || (k == 5);
            default: phy_soc <= (k == 0);
          endcase
          k++;
        end else begin
          phy_soc <= 1'b0;
        end
        if (modeled(phy_addr)) begin
          clav_drv <= 1'b1;
          clav_val <= (cells[phy_addr] > 0);
        end else begin
          clav_drv <= 1'b0;
        end
        pen = phy_en_n; paddr = phy_addr;
      end
    end
  end

  // Output and bus monitor
  int ncell = 0;
  int c_port [64];
  int c_words [64];
  int c_bad [64];
  int c_errs [64];
  int c_errpos [64];
  int hs_bad = 0, runs = 0, rd_polls = 0;
  initial begin
    int run, widx;
    logic pe;
    logic [4:0] pa;
    run = 0; widx = 0; pe = 1'b1; pa = 5'h1F;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!phy_en_n && pe) begin
          if (pa == 5'h1F) hs_bad++;
          run = 0;
        end
        if (!phy_en_n) begin
          run++;
          if (phy_addr != 5'h1F && !pe) rd_polls++;
        end
        if (phy_en_n && !pe) begin
          runs++;
          if (run != 27) hs_bad++;
        end
        if (out_valid) begin
          if (out_sof) begin
            widx = 0;
            c_port[ncell] = out_port; c_words[ncell] = 0; c_bad[ncell] = 0;
            c_errs[ncell] = 0; c_errpos[ncell] = -1;
            ncell++;
          end
          if (ncell > 0) begin
            c_words[ncell-1]++;
            if (out_port != c_port[ncell-1]) c_bad[ncell-1]++;
            if (out_data != {3'b000, out_port, 8'(widx)}) c_bad[ncell-1]++;
            if (out_eof != (widx == 26)) c_bad[ncell-1]++;
            if (out_err) begin
              c_errs[ncell-1]++;
              if (c_errpos[ncell-1] < 0) c_errpos[ncell-1] = widx;
            end
          end
          widx++;
        end
        pe = phy_en_n; pa = phy_addr;
      end
    end
  end

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(phy_en_n == 1'b1, "R1 enable in reset", phy_en_n, 1);
    check(phy_addr == 5'h1F, "R1 address in reset", phy_addr, 31);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    @(negedge clk) rst_n = 1'b1;
    check(phy_en_n == 1'b1 && phy_addr == 5'h1F && !out_valid,
          "R1 first clock after reset", phy_addr, 31);
  endtask

  task automatic t_poll_idle;
    logic [4:0] seq [24];
    int first, bad;
    logic [4:0] lst [4];
    lst[0] = 5'h01; lst[1] = 5'h03; lst[2] = 5'h05; lst[3] = 5'h07;
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      seq[i] = phy_addr;
      if (!phy_en_n) bad++;
    end
    check(bad == 0, "R2 enable stays high with no cells", bad, 0);
    first = (seq[0] == 5'h1F) ? 1 : 0;
    bad = 0;
    begin
      int p;
      p = 0;
      for (int q = 0; q < 4; q++) if (lst[q] == seq[first]) p = q;
      for (int i = first; i < 24; i++) begin
        if (((i - first) % 2) == 1) begin
          if (seq[i] != 5'h1F) bad++;
        end else begin
          if (seq[i] != lst[(p + (i - first) / 2) % 4]) bad++;
        end
      end
    end
    check(bad == 0, "R2 poll address sequence", bad, 0);
  endtask

  task automatic t_single;
    int base;
    base = ncell;
    @(negedge clk) cells[5'h03] = 1;
    repeat (150) @(negedge clk);
    check(ncell - base == 1, "R3 one cell from flagged port", ncell - base, 1);
    if (ncell - base >= 1) begin
      check(c_port[base] == 3, "R3 port tag", c_port[base], 3);
      check(c_words[base] == 27, "R5 word count", c_words[base], 27);
      check(c_bad[base] == 0, "R5 order, tag and last marker", c_bad[base], 0);
      check(c_errs[base] == 0, "R7 no error on aligned cell", c_errs[base], 0);
    end
    check(hs_bad == 0, "R4 select handshake and run length", hs_bad, 0);
  endtask

  function automatic int nxt(input int p);
    case (p)
      1: return 3;
      3: return 7;
      default: return 1;
    endcase
  endfunction

  task automatic t_rr;
    int base, bad, cnt1, cnt3, cnt7, p0;
    base = ncell; p0 = rd_polls;
    @(negedge clk);
    cells[5'h01] = 2; cells[5'h03] = 2; cells[5'h07] = 2;
    repeat (600) @(negedge clk);
    check(ncell - base == 6, "R6 six cells served", ncell - base, 6);
    bad = 0; cnt1 = 0; cnt3 = 0; cnt7 = 0;
    for (int i = base; i < ncell; i++) begin
      if (c_port[i] == 1) cnt1++;
      if (c_port[i] == 3) cnt3++;
      if (c_port[i] == 7) cnt7++;
      if (c_words[i] != 27 || c_bad[i] != 0) bad++;
      if (i > base && c_port[i] != nxt(c_port[i-1]))
        check(0, "R6 rotation order", c_port[i], nxt(c_port[i-1]));
    end
    check(cnt1 == 2 && cnt3 == 2 && cnt7 == 2, "R6 two cells per port", cnt1*100+cnt3*10+cnt7, 222);
    check(bad == 0, "R5 cell contents under back-to-back reads", bad, 0);
    check(rd_polls - p0 > 0, "R8 polling continues during reads", rd_polls - p0, 1);
    check(hs_bad == 0, "R4 handshake on back-to-back reads", hs_bad, 0);
  endtask

  task automatic t_float;
    int cnt5;
    cnt5 = 0;
    for (int i = 0; i < ncell; i++) if (c_port[i] == 5) cnt5++;
    check(cnt5 == 0, "R9 floating available line never read", cnt5, 0);
  endtask

  task automatic t_soc(input int mode, input int exp_pos);
    int base;
    base = ncell;
    @(negedge clk) begin soc_mode = mode; cells[5'h07] = 1; end
    repeat (150) @(negedge clk);
    soc_mode = 0;
    check(ncell - base == 1, "R7 cell received", ncell - base, 1);
    if (ncell - base >= 1) begin
      check(c_errs[base] == 1, "R7 error count", c_errs[base], 1);
      check(c_errpos[base] == exp_pos, "R7 error position", c_errpos[base], exp_pos);
    end
  endtask

  initial begin
    t_reset;
    t_poll_idle;
    t_single;
    t_rr;
    t_float;
    t_soc(1, 0);
    t_soc(2, 5);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule